// File: doc/BRIEF.md
# Segmented DAC Switch Decoder

This block turns a 10-bit binary converter code into the switch enables of a segmented current-steering array. The upper five bits of the code select how many of 31 equal intermediate segments are on, using a thermometer pattern. The lower five bits enable five binary-weighted sources directly. Each source has a second, complementary enable that steers its current to the other output. As a result the primary output reaches full scale at the all-ones code, and the complementary output reaches full scale at the all-zeros code.

The code is captured on the rising clock edge together with a sleep request. One clock later the decoded enables are registered, so that every enable changes on the same edge. While sleep is captured high, every source is switched off on both paths. A toggle-count output reports how many primary enable lines changed between consecutive captured codes. This makes the distribution of switching activity across the code range visible. One case it shows is the midscale step, which moves only six lines.

Top module: `seg_dac_decoder`

## Requirements
- R1: A code and sleep value present at a rising edge appear on the enable outputs after the second rising edge, and all enables update on that same edge.
- R2: The number of enabled segments on `seg_on` equals the value of the upper five code bits, from 0 to 31.
- R3: Segments fill from index 0 upward: `seg_on[k]` is 1 exactly when the upper-field value is greater than k.
- R4: `bin_on[j]` equals code bit j for j = 0..4, so bit j drives the source of weight 2^j LSB.
- R5: Outside sleep, every complementary enable (`seg_on_n`, `bin_on_n`) is the inverse of its primary enable. The all-ones code gives all primaries on, and the all-zeros code gives all complementaries on.
- R6: While the captured sleep bit is 1, all primary and all complementary enables are 0. After sleep is released, the outputs again show the current code.
- R7: While the synchronous active-high reset is asserted, all primaries are 0, all complementaries are 1, `toggle_cnt` is 0, and the captured code is 0.
- R8: `toggle_cnt` equals the number of the 36 primary lines whose decoded value differs between the current and the previous captured code. Sleep has no effect on this count.
- R9: The step from code 0x1FF to 0x200 turns one segment on and five binary sources off, giving a count of 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| sleep | input | 1 | Power-down request, active high, captured with the code |
| code_in | input | 10 | Binary converter code, bit 9 most significant |
| seg_on | output | 31 | Primary enables of the equal segments (thermometer) |
| seg_on_n | output | 31 | Complementary enables of the segments |
| bin_on | output | 5 | Primary enables of the binary-weighted sources |
| bin_on_n | output | 5 | Complementary enables of the binary sources |
| toggle_cnt | output | 6 | Primary lines changed by the last code update |

## Verification
The assertions assume that reset is held for at least two edges before it is released. The latency property only compares the outputs with the code from two edges earlier after two clean, reset-free edges have passed. The bench meets this assumption by holding reset for several cycles. It changes the code and sleep only on falling edges and holds each value for three cycles, so every captured code is seen at a stable output. The stimulus covers every code in ascending order, then a set of scattered jumps, and then sleep entry and exit around fixed codes.

// File: rtl/seg_dac_decoder.sv
module seg_dac_decoder #(
  parameter int CODE_W = 10,
  parameter int MSB_W  = 5
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             sleep,
  input  logic [CODE_W-1:0]                code_in,
  output logic [(1<<MSB_W)-2:0]            seg_on,
  output logic [(1<<MSB_W)-2:0]            seg_on_n,
  output logic [CODE_W-MSB_W-1:0]          bin_on,
  output logic [CODE_W-MSB_W-1:0]          bin_on_n,
  output logic [$clog2((1<<MSB_W)-1+CODE_W-MSB_W+1)-1:0] toggle_cnt
);
  localparam int LSB_W = CODE_W - MSB_W;
  localparam int SEG_N = (1 << MSB_W) - 1;
  localparam int LINES = SEG_N + LSB_W;
  localparam int CNT_W = $clog2(LINES + 1);

  logic [CODE_W-1:0] code_q;
  logic              sleep_q;
  logic [MSB_W-1:0]  upper;
  logic [SEG_N-1:0]  therm;
  logic [LINES-1:0]  dec_now, dec_q, prim_q, comp_q, flip;
  logic [CNT_W-1:0]  flips;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q  <= '0;
      sleep_q <= 1'b0;
    end else begin
      code_q  <= code_in;
      sleep_q <= sleep;
    end
  end

  assign upper = code_q[CODE_W-1:LSB_W];

  for (genvar k = 0; k < SEG_N; k++) begin : g_seg
    assign therm[k] = (upper > MSB_W'(k));
  end

  assign dec_now = {therm, code_q[LSB_W-1:0]};
  assign flip    = dec_now ^ dec_q;

  always_comb begin
    flips = '0;
    for (int i = 0; i < LINES; i++) flips = flips + CNT_W'(flip[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_q  <= '0;
      prim_q <= '0;
      comp_q <= '1;
      cnt_q  <= '0;
    end else begin
      dec_q  <= dec_now;
      cnt_q  <= flips;
      prim_q <= sleep_q ? '0 : dec_now;
      comp_q <= sleep_q ? '0 : ~dec_now;
    end
  end

  assign seg_on     = prim_q[LINES-1:LSB_W];
  assign bin_on     = prim_q[LSB_W-1:0];
  assign seg_on_n   = comp_q[LINES-1:LSB_W];
  assign bin_on_n   = comp_q[LSB_W-1:0];
  assign toggle_cnt = cnt_q;
endmodule

// File: rtl/seg_dac_decoder_chk.sv
module seg_dac_decoder_chk #(
  parameter int CODE_W = 10,
  parameter int MSB_W  = 5
) (
  input logic                             clk,
  input logic                             rst,
  input logic [CODE_W-1:0]                code_in,
  input logic [(1<<MSB_W)-2:0]            seg_on,
  input logic [(1<<MSB_W)-2:0]            seg_on_n,
  input logic [CODE_W-MSB_W-1:0]          bin_on,
  input logic [CODE_W-MSB_W-1:0]          bin_on_n,
  input logic [$clog2((1<<MSB_W)-1+CODE_W-MSB_W+1)-1:0] toggle_cnt
);
  localparam int LSB_W = CODE_W - MSB_W;
  localparam int SEG_N = (1 << MSB_W) - 1;
  localparam int LINES = SEG_N + LSB_W;

  logic [1:0] since;
  logic       active;

  always_ff @(posedge clk) begin
    if (rst) since <= '0;
    else if (since != 2'd3) since <= since + 2'd1;
  end

  assign active = |{seg_on, bin_on, seg_on_n, bin_on_n};

  p_therm_shape_r3: assert property (@(posedge clk) disable iff (rst)
    ((seg_on & (seg_on + 1'b1)) == '0));

  p_paths_inverse_r5: assert property (@(posedge clk) disable iff (rst)
    active |-> ({seg_on_n, bin_on_n} == ~{seg_on, bin_on}));

  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    (active && since >= 2'd2) |->
      ($countones(seg_on) == int'($past(code_in[CODE_W-1:LSB_W], 2)) &&
       bin_on == $past(code_in[LSB_W-1:0], 2)));

  p_count_range_r8: assert property (@(posedge clk) disable iff (rst)
    int'(toggle_cnt) <= LINES);
endmodule

bind seg_dac_decoder seg_dac_decoder_chk #(.CODE_W(CODE_W), .MSB_W(MSB_W)) u_chk (
  .clk(clk), .rst(rst), .code_in(code_in),
  .seg_on(seg_on), .seg_on_n(seg_on_n),
  .bin_on(bin_on), .bin_on_n(bin_on_n),
  .toggle_cnt(toggle_cnt)
);

// File: tb/test_seg_dac_decoder.sv
`timescale 1ns/1ps
module test_seg_dac_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sleep = 1'b0;
  logic [9:0]  code_in = 10'h3FF;
  logic [30:0] seg_on, seg_on_n;
  logic [4:0]  bin_on, bin_on_n;
  logic [5:0]  toggle_cnt;

  int checks = 0;
  int fails  = 0;
  int prev   = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  seg_dac_decoder i_seg_dac_decoder (
    .clk(clk), .rst(rst), .sleep(sleep), .code_in(code_in),
    .seg_on(seg_on), .seg_on_n(seg_on_n),
    .bin_on(bin_on), .bin_on_n(bin_on_n),
    .toggle_cnt(toggle_cnt)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [30:0] therm_of(input int m);
    logic [31:0] t;
    t = (32'd1 << m) - 32'd1;
    return t[30:0];
  endfunction

  function automatic int diff_of(input int a, input int b);
    int ma, mb, d;
    ma = a >> 5; mb = b >> 5;
    d = (ma > mb) ? ma - mb : mb - ma;
    return d + $countones((a ^ b) & 31);
  endfunction

  task automatic apply(input int c, input bit slp);
    @(negedge clk);
    code_in = c[9:0];
    sleep = slp;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic verify(input int c, input bit slp);
    logic [30:0] es;
    logic [4:0]  eb;
    es = slp ? 31'd0 : therm_of(c >> 5);
    eb = slp ? 5'd0 : c[4:0];
    check(seg_on == es, slp ? "R6 seg off" : "R2/R3 seg", seg_on, es);
    if (!slp) check($countones(seg_on) == (c >> 5), "R2 count", $countones(seg_on), c >> 5);
    check(bin_on == eb, slp ? "R6 bin off" : "R4 bin", bin_on, eb);
    check(seg_on_n == (slp ? 31'd0 : ~es), slp ? "R6 seg_n off" : "R5 seg_n", seg_on_n, slp ? 31'd0 : ~es);
    check(bin_on_n == (slp ? 5'd0 : ~eb), slp ? "R6 bin_n off" : "R5 bin_n", bin_on_n, slp ? 5'd0 : ~eb);
    check(int'(toggle_cnt) == diff_of(c, prev), "R8 toggle", toggle_cnt, diff_of(c, prev));
    prev = c;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R7: reset state with a full-scale code on the input
    check(seg_on == 31'd0 && bin_on == 5'd0, "R7 primaries", {seg_on, bin_on}, 0);
    check(seg_on_n == '1 && bin_on_n == '1, "R7 complementaries", {seg_on_n, bin_on_n}, 36'hFFFFFFFFF);
    check(toggle_cnt == 6'd0, "R7 count", toggle_cnt, 0);
    code_in = 10'd0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    verify(0, 1'b0);

    // R1: output changes only after the second edge
    @(negedge clk);
    code_in = 10'h2A5;
    @(negedge clk);
    check(seg_on == 31'd0 && bin_on == 5'd0, "R1 after one edge", {seg_on, bin_on}, 0);
    @(negedge clk);
    verify(10'h2A5, 1'b0);

    // R2 R3 R4 R5 R8: exhaustive ascending sweep
    for (int c = 0; c < 1024; c++) begin
      apply(c, 1'b0);
      verify(c, 1'b0);
    end

    // R9: midscale step and full-scale ends
    apply(10'h1FF, 1'b0); verify(10'h1FF, 1'b0);
    apply(10'h200, 1'b0); verify(10'h200, 1'b0);
    check(toggle_cnt == 6'd6, "R9 midscale toggles", toggle_cnt, 6);
    apply(10'h3FF, 1'b0); verify(10'h3FF, 1'b0);
    check(seg_on == '1 && bin_on == '1, "R5 all-ones primaries full", {seg_on, bin_on}, 36'hFFFFFFFFF);
    apply(10'h000, 1'b0); verify(10'h000, 1'b0);
    check(seg_on_n == '1 && bin_on_n == '1, "R5 all-zeros complementaries full", {seg_on_n, bin_on_n}, 36'hFFFFFFFFF);

    // R8: scattered jumps
    for (int i = 0; i < 64; i++) begin
      apply((i * 389 + 77) & 1023, 1'b0);
      verify((i * 389 + 77) & 1023, 1'b0);
    end

    // R6: sleep gating, count unaffected, recovery
    apply(10'h155, 1'b0); verify(10'h155, 1'b0);
    apply(10'h2AA, 1'b1); verify(10'h2AA, 1'b1);
    apply(10'h3FF, 1'b1); verify(10'h3FF, 1'b1);
    apply(10'h3FF, 1'b0); verify(10'h3FF, 1'b0);
    apply(10'h0F0, 1'b0); verify(10'h0F0, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule